// File: doc/BRIEF.md
# Receive Pre-Pad Byte Injector

This block sits between the byte-wide receive stream of an Ethernet MAC and the write port of a receive FIFO. While the receive path is idle, it writes a fixed number of 0x00 filler octets into the FIFO. By default that number is two. Every stored frame therefore starts with a 2-byte prefix. The 14-byte Ethernet header then ends on a 4-byte boundary once the FIFO widens the stream. The frame bytes follow the filler, in order, with one cycle of latency.

The incoming stream is registered once. The write decision is taken on that delayed copy. Each cycle, the control logic either tops up the filler or writes a frame byte. It never does both in one cycle.

For every frame written in full, the block reports the frame length with the filler bytes excluded. It also keeps a saturating count of frames it had to discard and a sticky flag that records when a frame arrived before the filler was complete.

Top module: `rx_pre_pad`

## Requirements
- R1: After reset release, `frame_len_o`, `frame_done_o`, `drop_cnt_o` and `pad_err_o` are 0. With `fifo_full_i` low, exactly two writes of 0x00 occur in the first two cycles, and none follow while idle.
- R2: For each accepted frame, the FIFO receives the two 0x00 filler octets followed by every frame byte in arrival order. A byte sampled at a clock edge is written in the cycle that follows that edge.
- R3: `fifo_wen_o` is never high while `fifo_full_i` is high.
- R4: After the last byte of an accepted frame is written, `frame_done_o` pulses high for one cycle. In that same cycle, `frame_len_o` holds the number of frame bytes, with the filler excluded.
- R5: A frame byte that arrives before both filler octets are written sets `pad_err_o`. The flag stays set until reset. None of that frame's bytes are written, `drop_cnt_o` increments, the filler is completed, and the next frame is stored correctly.
- R6: While `fifo_full_i` is high, filler writes stall. They resume when it falls, until two octets are stored.
- R7: If `fifo_full_i` is high when a frame byte is due, that byte and the rest of the frame are not written. `drop_cnt_o` increments, no `frame_done_o` pulse occurs, and the next frame gets fresh filler.
- R8: A one-byte frame (valid and last in the same cycle) is written after its filler and reported with length 1.
- R9: Data and last-flag activity while `rx_valid_i` is low causes no FIFO write and no frame report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte valid strobe |
| rx_last_i | input | 1 | Marks the final byte of a frame, qualified by valid |
| fifo_full_i | input | 1 | FIFO cannot accept a write this cycle |
| fifo_wdata_o | output | 8 | FIFO write data |
| fifo_wen_o | output | 1 | FIFO write enable |
| frame_len_o | output | 11 | Length of the last accepted frame, filler excluded |
| frame_done_o | output | 1 | One-cycle pulse when `frame_len_o` is updated |
| drop_cnt_o | output | 8 | Saturating count of discarded frames |
| pad_err_o | output | 1 | Sticky flag: a frame started before the filler was complete |

## Verification
The assertions assume the following about the inputs:
- `rx_last_i` matters only when `rx_valid_i` is high.
- The MAC cannot be stalled.
- A frame is shorter than 2^11 minus the filler count.

The stimulus keeps frames between 1 and 100 bytes long. It leaves at least two idle cycles between frames, except in the one case that deliberately starts a frame too early. It raises the FIFO-full input only during the reset-held idle period and in the middle of a single frame.

// File: rtl/rx_pad_pkg.sv
package rx_pad_pkg;
  typedef enum logic [1:0] {
    ST_PAD  = 2'd0,
    ST_RCV  = 2'd1,
    ST_DROP = 2'd2
  } rx_st_e;
endpackage

// File: rtl/rx_pad_stage.sv
module rx_pad_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      data_o  <= data_i;
      valid_o <= valid_i;
      last_o  <= valid_i & last_i;
    end
  end
endmodule

// File: rtl/rx_pad_ctrl.sv
module rx_pad_ctrl
  import rx_pad_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PAD_BYTES = 2,
  parameter int LEN_W     = 11,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              fifo_full_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wen_o,
  output logic              frame_ok_o,
  output logic [LEN_W-1:0]  frame_bytes_o,
  output logic              drop_o,
  output logic              early_o
);
  localparam logic [CNT_W-1:0] PAD_C = CNT_W'(PAD_BYTES);

  rx_st_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;   // bytes written this frame, filler included
  logic             pad_pend;
  logic [CNT_W-1:0] len_full;

  assign pad_pend = cnt_q < PAD_C;
  assign len_full = cnt_q + CNT_W'(1) - PAD_C;
  assign frame_bytes_o = len_full[LEN_W-1:0];

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    wen_o      = 1'b0;
    wdata_o    = '0;
    frame_ok_o = 1'b0;
    drop_o     = 1'b0;
    early_o    = 1'b0;
    unique case (st_q)
      ST_PAD: begin
        if (pad_pend) begin
          if (!fifo_full_i) begin
            wen_o = 1'b1;
            cnt_d = cnt_q + CNT_W'(1);
          end
          if (valid_i) begin  // frame arrived too early: discard it, keep filler
            early_o = 1'b1;
            drop_o  = 1'b1;
            if (!last_i) st_d = ST_DROP;
          end
        end else if (valid_i) begin
          if (fifo_full_i) begin
            drop_o = 1'b1;
            if (!last_i) st_d = ST_DROP;
          end else begin
            wen_o   = 1'b1;
            wdata_o = data_i;
            if (last_i) begin
              frame_ok_o = 1'b1;
              cnt_d      = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
              st_d  = ST_RCV;
            end
          end
        end
      end
      ST_RCV: begin
        if (valid_i) begin
          if (fifo_full_i) begin
            drop_o = 1'b1;
            cnt_d  = '0;
            st_d   = last_i ? ST_PAD : ST_DROP;
          end else begin
            wen_o   = 1'b1;
            wdata_o = data_i;
            if (last_i) begin
              frame_ok_o = 1'b1;
              cnt_d      = '0;
              st_d       = ST_PAD;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
      end
      ST_DROP: begin
        if (pad_pend && !fifo_full_i) begin
          wen_o = 1'b1;
          cnt_d = cnt_q + CNT_W'(1);
        end
        if (valid_i && last_i) st_d = ST_PAD;
      end
      default: st_d = ST_PAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PAD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_o |-> !fifo_full_i);  // R3
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_o && pad_pend) |-> (wdata_o == '0));  // R2
  AST_IDLE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RCV) |-> (cnt_q <= PAD_C));  // R2
  AST_RCV_PADDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RCV) |-> (cnt_q > PAD_C));  // R2
  AST_EARLY_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> (wdata_o == '0));  // R5
endmodule

// File: rtl/rx_pad_stats.sv
module rx_pad_stats #(
  parameter int LEN_W  = 11,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ok_i,
  input  logic [LEN_W-1:0]  frame_bytes_i,
  input  logic              drop_i,
  input  logic              early_i,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              frame_done_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              pad_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_len_o  <= '0;
      frame_done_o <= 1'b0;
      drop_cnt_o   <= '0;
      pad_err_o    <= 1'b0;
    end else begin
      frame_done_o <= frame_ok_i;
      if (frame_ok_i) frame_len_o <= frame_bytes_i;
      if (drop_i && (drop_cnt_o != '1)) drop_cnt_o <= drop_cnt_o + DROP_W'(1);
      if (early_i) pad_err_o <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pad_err_o) |-> pad_err_o);  // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);  // R4
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (frame_len_o != '0));  // R4
  AST_DROP_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_cnt_o >= $past(drop_cnt_o));  // R7
endmodule

// File: rtl/rx_pre_pad.sv
module rx_pre_pad #(
  parameter int DATA_W    = 8,
  parameter int PAD_BYTES = 2,
  parameter int LEN_W     = 11,
  parameter int DROP_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  input  logic              fifo_full_i,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_wen_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              frame_done_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              pad_err_o
);
  logic [DATA_W-1:0] d1_data;
  logic              d1_valid, d1_last;
  logic              frame_ok, drop_evt, early_evt;
  logic [LEN_W-1:0]  frame_bytes;

  rx_pad_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i, .rst_ni,
    .data_i (rx_data_i), .valid_i(rx_valid_i), .last_i(rx_last_i),
    .data_o (d1_data),   .valid_o(d1_valid),   .last_o(d1_last)
  );

  rx_pad_ctrl #(.DATA_W(DATA_W), .PAD_BYTES(PAD_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .data_i       (d1_data),
    .valid_i      (d1_valid),
    .last_i       (d1_last),
    .fifo_full_i,
    .wdata_o      (fifo_wdata_o),
    .wen_o        (fifo_wen_o),
    .frame_ok_o   (frame_ok),
    .frame_bytes_o(frame_bytes),
    .drop_o       (drop_evt),
    .early_o      (early_evt)
  );

  rx_pad_stats #(.LEN_W(LEN_W), .DROP_W(DROP_W)) u_stats (
    .clk_i, .rst_ni,
    .frame_ok_i   (frame_ok),
    .frame_bytes_i(frame_bytes),
    .drop_i       (drop_evt),
    .early_i      (early_evt),
    .frame_len_o,
    .frame_done_o,
    .drop_cnt_o,
    .pad_err_o
  );

  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(fifo_wen_o));  // R4
endmodule

// File: tb/rx_pre_pad_bench.sv
`timescale 1ns/1ps
module rx_pre_pad_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, fifo_full = 1'b0;
  logic [7:0]  fifo_wdata;
  logic        fifo_wen;
  logic [10:0] frame_len;
  logic        frame_done;
  logic [7:0]  drop_cnt;
  logic        pad_err;

  always #2.5 clk = ~clk;

  rx_pre_pad u_rx_pre_pad (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_last_i(rx_last),
    .fifo_full_i(fifo_full),
    .fifo_wdata_o(fifo_wdata), .fifo_wen_o(fifo_wen),
    .frame_len_o(frame_len), .frame_done_o(frame_done),
    .drop_cnt_o(drop_cnt), .pad_err_o(pad_err)
  );

  // {len[11:0], gap[3:0]}
  localparam logic [15:0] FRAMES [6] = '{16'h00E3, 16'h03C2, 16'h0405, 16'h0012, 16'h0072, 16'h0644};

  int total = 0, bad = 0, done_n = 0;
  logic [7:0] log_q [4096];
  logic [7:0] exp_q [4096];
  int wn = 0, en = 0, wp = 0, ep = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wen && wn < 4096) begin log_q[wn] = fifo_wdata; wn++; end
      if (frame_done) done_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic [7:0] b);
    exp_q[en] = b; en++;
  endtask

  task automatic chk_stream(string req);
    bit ok;
    int act_b, exp_b;
    ok = (wn - wp) == (en - ep);
    act_b = wn - wp; exp_b = en - ep;
    if (ok) begin
      for (int i = 0; i < wn - wp; i++) begin
        if (ok && log_q[wp+i] !== exp_q[ep+i]) begin
          ok = 0; act_b = log_q[wp+i]; exp_b = exp_q[ep+i];
        end
      end
    end
    chk(ok, req, "fifo stream", act_b, exp_b);
    wp = wn; ep = en;
  endtask

  task automatic do_reset(logic full);
    @(posedge clk); #1;
    rst_n = 1'b0; fifo_full = full; rx_valid = 1'b0; rx_last = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wp = wn; ep = en;
  endtask

  task automatic send_frame(int len, int base, int gap, int full_from);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = 8'(base + i); rx_last = (i == len - 1);
      fifo_full = (i >= full_from);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0; fifo_full = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d0;
    do_reset(1'b0);
    @(negedge clk);
    chk(frame_len == 0 && !frame_done, "R1", "reset len/done", frame_len, 0);
    chk(drop_cnt == 0 && !pad_err, "R1", "reset drop/err", drop_cnt, 0);
    settle();
    push(8'h00); push(8'h00);
    chk_stream("R1");

    // R9: data and last toggle with valid low
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1; rx_data = 8'(i * 37 + 5); rx_last = i[0];
    end
    @(posedge clk); #1; rx_last = 1'b0;
    settle();
    chk_stream("R9");
    chk(done_n == 0, "R9", "no frame report", done_n, 0);

    // table walk: R2 R4
    for (int k = 0; k < 6; k++) begin
      int len, gap, base;
      len = int'(FRAMES[k][15:4]); gap = int'(FRAMES[k][3:0]); base = k * 16 + 3;
      d0 = done_n;
      for (int i = 0; i < len; i++) push(8'(base + i));
      push(8'h00); push(8'h00);
      send_frame(len, base, gap, 9999);
      settle();
      chk_stream("R2");
      chk(frame_len == 11'(len), "R4", "frame len", frame_len, len);
      chk(done_n == d0 + 1, "R4", "done pulses", done_n - d0, 1);
    end

    // R8: single-byte frame
    d0 = done_n;
    push(8'hA5); push(8'h00); push(8'h00);
    send_frame(1, 8'hA5, 2, 9999);
    settle();
    chk_stream("R8");
    chk(frame_len == 11'd1 && done_n == d0 + 1, "R8", "len of 1-byte frame", frame_len, 1);

    // R5: second frame starts before filler completes
    d0 = done_n;
    for (int i = 0; i < 6; i++) push(8'(8'h40 + i));
    push(8'h00); push(8'h00);
    send_frame(6, 8'h40, 0, 9999);
    send_frame(5, 8'h60, 0, 9999);
    settle();
    for (int i = 0; i < 9; i++) push(8'(8'h80 + i));
    push(8'h00); push(8'h00);
    send_frame(9, 8'h80, 2, 9999);
    settle();
    chk_stream("R5");
    chk(pad_err == 1'b1, "R5", "sticky err", pad_err, 1);
    chk(drop_cnt == 8'd1, "R5", "drop count", drop_cnt, 1);
    chk(done_n == d0 + 2 && frame_len == 11'd9, "R5", "following frame len", frame_len, 9);

    // R6: FIFO full during filler
    do_reset(1'b1);
    @(negedge clk);
    chk(drop_cnt == 0 && !pad_err, "R1", "second reset clears stats", pad_err, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!fifo_wen, "R3", "no write when full", fifo_wen, 0);
    end
    chk_stream("R6");
    @(posedge clk); #1 fifo_full = 1'b0;
    settle();
    push(8'h00); push(8'h00);
    chk_stream("R6");

    // R7: FIFO full mid-frame
    d0 = done_n;
    for (int i = 0; i < 3; i++) push(8'(8'hC0 + i));
    push(8'h00); push(8'h00);
    send_frame(10, 8'hC0, 2, 4);
    settle();
    chk_stream("R7");
    chk(drop_cnt == 8'd1, "R7", "drop count", drop_cnt, 1);
    chk(done_n == d0, "R7", "no report for dropped", done_n - d0, 0);
    for (int i = 0; i < 5; i++) push(8'(8'hE0 + i));
    push(8'h00); push(8'h00);
    send_frame(5, 8'hE0, 2, 9999);
    settle();
    chk_stream("R7");
    chk(frame_len == 11'd5 && done_n == d0 + 1, "R7", "next frame len", frame_len, 5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule